// File: doc/BRIEF.md
# Zigzag Quantizer

This block turns 8x8 blocks of signed transform coefficients into quantized values, emitted in zigzag order. The divide by the quantizer step is done as a multiply by a 12-bit reciprocal, followed by a right shift of 12 that rounds toward zero. The coefficient stream arrives column by column: the first eight samples of a block run down column 0, the next eight down column 1, and so on. The DC term of the stream is not used. In its place the block takes an 8-bit signed average from a side input, scales it by 8 and quantizes it like any other coefficient.

The host loads four 64-entry reciprocal tables before compression starts. These are two alternative sets, and each set holds one luma table and one chroma table. A set select and a chroma tag are sampled with each block's start marker, and that choice holds for the whole block. The reorder store is a ping-pong pair, so one block can be collected while the previous one streams out. Idle cycles may appear anywhere in the input, and back-to-back input gives gap-free output.

Top module: `zz_quant`

## Requirements
- R1: While `rst_n` is low, and after reset until a full block has been collected, `out_valid` and `out_first` stay 0.
- R2: A table write with `tbl_we` high stores `tbl_data` (unsigned 12-bit) at `tbl_addr`. Bit 7 of the address is the set, bit 6 is the component (0 luma, 1 chroma), and bits 5:0 are the natural position row*8+col. The new entry applies from the next clock on.
- R3: Each output equals the coefficient times its table entry divided by 4096, with the quotient truncated toward zero. For example, -1 with entry 4095 gives 0.
- R4: Position row 0, col 0 takes `in_dc`*8 in place of the streamed coefficient. `in_dc` is sampled with the block start, and the value is quantized with table entry 0.
- R5: The k-th accepted sample of a block (k from 0) is the coefficient at row k mod 8, column k div 8.
- R6: Each block comes out as 64 values in zigzag order (0,0),(0,1),(1,0),(2,0),(1,1),(0,2),... `out_first` is high with the first value only.
- R7: `set_sel` and `in_chroma` are sampled when `in_valid` and `in_first` are both high. Changing them later in the block has no effect on that block.
- R8: Any number of idle cycles may occur between or within blocks. A block's first output is valid one clock after the edge that follows its last sample's edge. Back-to-back blocks produce back-to-back output.
- R9: `in_first` during a block discards the partial block and starts a new one. Samples with `in_valid` high outside an open block are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | {set, chroma, row*8+col} |
| tbl_data | input | 12 | Unsigned reciprocal entry |
| set_sel | input | 1 | Table set for the block that is starting |
| in_valid | input | 1 | Coefficient sample valid |
| in_first | input | 1 | First sample of a block |
| in_chroma | input | 1 | Component tag of the block that is starting |
| in_coef | input | 12 | Signed coefficient, column-major order |
| in_dc | input | 8 | Signed block average, sampled with `in_first` |
| out_valid | output | 1 | Output value valid |
| out_first | output | 1 | First value of an output block |
| out_data | output | 12 | Signed quantized value, zigzag order |

## Verification
The hardest situation to reach is a full ping-pong pair. The collecting bank must finish in exactly the cycle the draining bank empties, and that only happens under unbroken input. Unbroken blocks also have to alternate with gapped ones so that the reader sometimes waits and sometimes runs on. The stimulus sends runs of gap-free blocks with changing tags, then gapped blocks, an aborted partial block and stray samples, all against a per-cycle model of the output timing. Extreme coefficients against entries of 1 and 4095 reach the truncation toward zero on negative products.

// File: rtl/zz_quant.sv
module zz_quant #(
  parameter int CW = 12,
  parameter int QW = 12,
  parameter int DW = 8,
  parameter int SH = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic [7:0]           tbl_addr,
  input  logic [QW-1:0]        tbl_data,
  input  logic                 set_sel,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic                 in_chroma,
  input  logic signed [CW-1:0] in_coef,
  input  logic signed [DW-1:0] in_dc,
  output logic                 out_valid,
  output logic                 out_first,
  output logic signed [CW-1:0] out_data
);
  localparam int PW = CW + QW + 1;

  function automatic logic [5:0] zz_nat(input int p);
    int n, row, col;
    logic [5:0] r;
    n = 0;
    r = '0;
    for (int s = 0; s < 15; s++)
      for (int j = 0; j < 8; j++) begin
        row = s[0] ? j : s - j;
        col = s - row;
        if (row < 8 && col < 8 && row >= 0 && col >= 0) begin
          if (n == p) r = 6'(row * 8 + col);
          n++;
        end
      end
    return r;
  endfunction

  logic [5:0] zz [64];
  for (genvar i = 0; i < 64; i++) begin : g_zz
    assign zz[i] = zz_nat(i);
  end

  logic [QW-1:0]        tbl [256];
  logic signed [CW-1:0] store [128];
  logic [1:0] full;
  logic       wr_bank, rd_bank, blk_open, blk_set, blk_comp;
  logic [5:0] wr_cnt, rd_cnt;

  wire        acc      = in_valid & (in_first | blk_open);
  wire [5:0]  k        = in_first ? 6'd0 : wr_cnt;
  wire [5:0]  nat      = {k[2:0], k[5:3]};
  wire        cur_set  = in_first ? set_sel : blk_set;
  wire        cur_comp = in_first ? in_chroma : blk_comp;
  wire [QW-1:0] q      = tbl[{cur_set, cur_comp, nat}];
  wire signed [CW-1:0] dcs = {{(CW-DW-3){in_dc[DW-1]}}, in_dc, 3'b000};
  wire signed [CW-1:0] c   = (k == 6'd0) ? dcs : in_coef;
  wire signed [PW-1:0] prod   = PW'(c) * PW'($signed({1'b0, q}));
  wire signed [PW-1:0] biased = prod + (prod[PW-1] ? PW'((1 << SH) - 1) : PW'(0));
  wire signed [CW-1:0] qv     = CW'(biased >>> SH);
  wire        wr_hit_full = acc & full[wr_bank];

  always_ff @(posedge clk) begin
    if (tbl_we) tbl[tbl_addr] <= tbl_data;
    if (acc) store[{wr_bank, nat}] <= qv;
    out_data <= store[{rd_bank, zz[rd_cnt]}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= '0;
      wr_bank   <= 1'b0;
      rd_bank   <= 1'b0;
      blk_open  <= 1'b0;
      blk_set   <= 1'b0;
      blk_comp  <= 1'b0;
      wr_cnt    <= '0;
      rd_cnt    <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_valid <= full[rd_bank];
      out_first <= full[rd_bank] && rd_cnt == 6'd0;
      if (full[rd_bank]) begin
        rd_cnt <= rd_cnt + 6'd1;
        if (rd_cnt == 6'd63) begin
          full[rd_bank] <= 1'b0;
          rd_bank       <= ~rd_bank;
        end
      end
      if (acc) begin
        wr_cnt   <= k + 6'd1;
        blk_open <= k != 6'd63;
        if (in_first) begin
          blk_set  <= set_sel;
          blk_comp <= in_chroma;
        end
        if (k == 6'd63) begin
          full[wr_bank] <= 1'b1;
          wr_bank       <= ~wr_bank;
        end
      end
    end
  end
endmodule

// File: rtl/zz_quant_chk.sv
module zz_quant_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_first,
  input logic       in_valid,
  input logic       in_first,
  input logic       blk_open,
  input logic       blk_set,
  input logic       blk_comp,
  input logic [5:0] wr_cnt,
  input logic       wr_hit_full
);
  logic [5:0] oc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oc <= '0;
    else if (out_valid) oc <= oc + 6'd1;

  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_first);
  a_r6_first_marks_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == (oc == 6'd0)));
  a_r6_first_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
  a_r8_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && oc != 6'd63 |=> out_valid);
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n) !wr_hit_full);
  a_r7_tags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_first) |=> $stable(blk_set) && $stable(blk_comp));
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_open && !(in_valid && in_first) |=> $stable(wr_cnt) && !blk_open);
endmodule

bind zz_quant zz_quant_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_first(out_first),
  .in_valid(in_valid), .in_first(in_first), .blk_open(blk_open),
  .blk_set(blk_set), .blk_comp(blk_comp), .wr_cnt(wr_cnt), .wr_hit_full(wr_hit_full)
);

// File: tb/test_zz_quant.sv
`timescale 1ns/1ps
module test_zz_quant;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, set_sel = 0, in_valid = 0, in_first = 0, in_chroma = 0;
  logic [7:0] tbl_addr = 0;
  logic [11:0] tbl_data = 0;
  logic signed [11:0] in_coef = 0;
  logic signed [7:0] in_dc = 0;
  logic out_valid, out_first;
  logic signed [11:0] out_data;

  always #2 clk = ~clk;

  zz_quant i_zz_quant (.*);

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  int tbl_m [256];
  int zz_m [64];
  int blk_m [64];
  int ready_q [$];
  int m_nblk, m_pos, m_k;
  bit m_act, m_open, m_set, m_comp;
  bit e_valid, e_first;
  int e_data;

  initial begin
    int r, c;
    bit up;
    r = 0; c = 0; up = 1;
    for (int i = 0; i < 64; i++) begin
      zz_m[i] = r * 8 + c;
      if (up) begin
        if (c == 7) begin r++; up = 0; end
        else if (r == 0) begin c++; up = 0; end
        else begin r--; c++; end
      end else begin
        if (r == 7) begin c++; up = 1; end
        else if (c == 0) begin r++; up = 1; end
        else begin r++; c--; end
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_nblk = 0; m_act = 0; m_open = 0; m_pos = 0; m_k = 0;
      e_valid = 0; e_first = 0; ready_q.delete();
    end else begin
      if (!m_act && m_nblk > 0) begin m_act = 1; m_pos = 0; m_nblk--; end
      if (m_act) begin
        e_valid = 1; e_first = (m_pos == 0); e_data = ready_q.pop_front();
        m_pos++;
        if (m_pos == 64) m_act = 0;
      end else begin
        e_valid = 0; e_first = 0;
      end
      if (in_valid) begin
        if (in_first) begin m_open = 1; m_k = 0; m_set = set_sel; m_comp = in_chroma; end
        if (m_open) begin
          int row, col, cv, qv;
          row = m_k % 8; col = m_k / 8;
          if (m_k == 0) begin cv = in_dc; cv = cv * 8; end else cv = in_coef;
          qv = tbl_m[m_set * 128 + m_comp * 64 + row * 8 + col];
          blk_m[row * 8 + col] = (cv * qv) / 4096;
          m_k++;
          if (m_k == 64) begin
            m_open = 0;
            for (int i = 0; i < 64; i++) ready_q.push_back(blk_m[zz_m[i]]);
            m_nblk++;
          end
        end
      end
      if (tbl_we) tbl_m[tbl_addr] = tbl_data;
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (out_valid !== e_valid) begin
      errors++;
      $display("FAIL %s out_valid actual=%b expected=%b", req, out_valid, e_valid);
    end else if (e_valid) begin
      checks++;
      if (out_first !== e_first || int'(out_data) != e_data) begin
        errors++;
        $display("FAIL %s first/data actual=%b/%0d expected=%b/%0d", req, out_first, out_data, e_first, e_data);
      end
    end else if (out_first !== 1'b0) begin
      errors++;
      $display("FAIL R6 out_first actual=%b expected=0", out_first);
    end
  end

  task automatic write_tables();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = 8'(i);
      case (i / 64)
        0: tbl_data = 12'(1 + (i * 53) % 4095);
        1: tbl_data = 12'(4095 - ((i * 29) % 2000));
        2: tbl_data = 12'd4095;
        default: tbl_data = 12'(1 << (i % 12));
      endcase
    end
    @(negedge clk); tbl_we = 0;
  endtask

  function automatic int coef(int mode, int k, int seed);
    case (mode)
      0: return ((k * 61 + seed * 17) % 4096) - 2048;
      1: return k[0] ? 2047 : -2048;
      2: return -1 - (k % 8);
      default: return ((k * k * 7 + seed) % 301) - 150;
    endcase
  endfunction

  task automatic send_block(int set, int comp, int dc, int mode, int seed, int gaps, bit flip, int len = 64);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_first = (k == 0);
      in_coef = 12'(coef(mode, k, seed));
      if (k == 0) begin set_sel = set[0]; in_chroma = comp[0]; in_dc = 8'(dc); end
      else if (flip) begin set_sel = ~set[0]; in_chroma = ~comp[0]; in_dc = 8'(-dc); end
      if (gaps > 0 && ((k + seed) % gaps) == 0) begin
        @(negedge clk); in_valid = 0; in_first = 0;
        repeat ((k + seed) % 3) @(negedge clk);
      end
    end
    @(negedge clk); in_valid = 0; in_first = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1 reset out_valid actual=%b expected=0", out_valid);
    end
    rst_n = 1;
    req = "R2";
    write_tables();
    repeat (3) @(negedge clk);
    req = "R3 R4 R5 R6";
    send_block(0, 0, 37, 0, 1, 0, 0);
    send_block(0, 1, -128, 3, 2, 0, 0);
    repeat (80) @(negedge clk);
    req = "R3 boundary";
    send_block(1, 0, 127, 1, 3, 0, 0);
    send_block(1, 0, -1, 2, 4, 0, 0);
    send_block(1, 1, -100, 1, 5, 0, 0);
    req = "R8 back-to-back";
    for (int b = 0; b < 6; b++) begin
      @(negedge clk); in_valid = 1; in_first = 1;
      set_sel = b[0]; in_chroma = b[1]; in_dc = 8'(b * 40 - 100);
      in_coef = 12'(coef(b % 4, 0, b));
      for (int k = 1; k < 64; k++) begin
        @(negedge clk); in_first = 0; in_coef = 12'(coef(b % 4, k, b));
      end
    end
    @(negedge clk); in_valid = 0;
    req = "R8 gaps";
    send_block(0, 1, 5, 3, 7, 5, 0);
    send_block(1, 1, -7, 0, 8, 3, 0);
    repeat (100) @(negedge clk);
    req = "R7 tags held";
    send_block(0, 0, 60, 0, 9, 0, 1);
    send_block(1, 1, -60, 3, 10, 4, 1);
    req = "R9 restart";
    send_block(1, 0, 11, 1, 11, 0, 0, 23);
    send_block(0, 1, 12, 0, 12, 0, 0);
    req = "R9 stray";
    repeat (7) begin @(negedge clk); in_valid = 1; in_first = 0; in_coef = 12'd999; end
    @(negedge clk); in_valid = 0;
    send_block(0, 0, 13, 3, 13, 2, 0);
    req = "R2 rewrite";
    @(negedge clk); tbl_we = 1; tbl_addr = 8'd0; tbl_data = 12'd4095;
    @(negedge clk); tbl_addr = 8'd1; tbl_data = 12'd1;
    @(negedge clk); tbl_we = 0;
    send_block(0, 0, -128, 1, 14, 0, 0);
    repeat (200) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule